// File: doc/BRIEF.md
# SDRAM Data Path Sequencer

This block watches the command stream a memory controller issues to a two-bank synchronous DRAM. It drives the per-cycle strobes for the shared DQ bus. It tells the pad logic when the controller must drive write data, which bytes of that data are live, and in which cycles returning read data is valid and should be captured. It also reports which bytes of captured read data are live, and in which cycles the DRAM itself drives the bus.

Commands arrive one per clock on an encoded input, qualified by an active-low chip select. Read data is timed by a programmable CAS latency of 2 or 3 cycles. Write data moves in the command cycle itself. Byte masks act on write data at once and on read data two cycles after they are presented. A burst ends early when a new read or write arrives, or when the bank it belongs to is precharged. After such a precharge the DRAM releases the bus at a delay that depends on the CAS latency.

Top module: `sdram_dq_sequencer`

## Requirements
- R1: While reset is asserted and afterwards with no command issued, dq_oe, dq_wr_be, rd_capture, rd_be and rd_bus_busy are all low.
- R2: A write (cmd 3) or write with auto-precharge (cmd 4) sets dq_oe in its own cycle and in the following cycles, for a total of 1, 2, 4 or 8 beats for cfg_burst codes 0, 1, 2 and 3.
- R3: A read (cmd 1) raises rd_capture for one burst of beats. The first beat comes L cycles after the command, where L is 2 when cfg_cl3 is 0 and 3 when cfg_cl3 is 1.
- R4: rd_bus_busy is high from L-1 cycles after each issued read beat through that beat's capture cycle. It is high in every cycle that rd_capture is high.
- R5: While dq_oe is high, dq_wr_be equals the inverse of dqm in the same cycle. Bit i of dqm high masks byte i, which is DQ bits 8i+7..8i. dq_wr_be is zero while dq_oe is low.
- R6: While rd_capture is high, rd_be equals the inverse of dqm from two cycles earlier. rd_be is zero otherwise.
- R7: A precharge-all command (cmd 6), or a single-bank precharge (cmd 5) naming the bank of the current burst, issued in cycle p, ends that burst. No write beat occurs from cycle p on, and no read beat is captured from cycle p+L on. A single-bank precharge of the other bank has no effect.
- R8: A read or write command during a burst abandons the beats of the earlier burst that have not yet been issued. A new full burst starts in the command cycle.
- R9: With cs_n high, the command input is ignored.
- R10: Read and write with auto-precharge (cmd 2 and cmd 4) produce the same data strobes as plain read and write.
- R11: In any cycle where dq_oe is high, rd_capture, rd_be and rd_bus_busy are low.
- R12: The CAS latency and burst length of a burst are taken when its command is issued. A later change of cfg_cl3 does not move the remaining beats of that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already released in step with clk |
| cfg_cl3 | input | 1 | CAS latency select: 0 gives 2 cycles, 1 gives 3 cycles |
| cfg_burst | input | 2 | Burst length code: 0, 1, 2, 3 give 1, 2, 4, 8 beats |
| cs_n | input | 1 | Active-low chip select qualifying cmd |
| cmd | input | 3 | 0 idle, 1 read, 2 read+AP, 3 write, 4 write+AP, 5 precharge bank, 6 precharge all |
| bank | input | BANK_W | Bank addressed by the command |
| dqm | input | NB | Per-byte mask, high masks the byte |
| dq_oe | output | 1 | Controller drives write data on DQ this cycle |
| dq_wr_be | output | NB | Live bytes of the write beat |
| rd_capture | output | 1 | Valid read data on DQ this cycle |
| rd_be | output | NB | Live bytes of the captured read beat |
| rd_bus_busy | output | 1 | DRAM drives DQ (low impedance) this cycle |

## Verification
The checker watches several properties on every cycle. It checks that write strobes and write byte enables follow the command and dqm with no delay. It checks that read byte enables follow dqm exactly two cycles late. It checks that a read arrives at latency 2 or 3 unless a write owns the bus, that the bus never has two drivers, and that capture only happens while the DRAM drives. Some behaviour can only be seen through the bench's scenarios, because it needs whole-burst shapes compared against expected cycle patterns. This covers burst length, the early end of a burst on precharge of the matching bank (and the lack of effect from the other bank), interruption by a new command, chip-select gating, and the latching of latency at command time.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE   = 3'd0,
    CMD_RD     = 3'd1,
    CMD_RD_AP  = 3'd2,
    CMD_WR     = 3'd3,
    CMD_WR_AP  = 3'd4,
    CMD_PRE    = 3'd5,
    CMD_PREALL = 3'd6
  } sdp_cmd_e;

endpackage

// File: rtl/sdp_cmd_decode.sv
module sdp_cmd_decode
  import sdp_pkg::*;
#(
  parameter int BANK_W = 1
) (
  input  logic [2:0]        cmd,
  input  logic              cs_n,
  input  logic [BANK_W-1:0] bank,
  input  logic [BANK_W-1:0] burst_bank,
  output logic              start_rd,
  output logic              start_wr,
  output logic              stop
);

  sdp_cmd_e cmd_e;

  assign cmd_e = sdp_cmd_e'(cmd);

  always_comb begin
    start_rd = 1'b0;
    start_wr = 1'b0;
    stop     = 1'b0;
    if (!cs_n) begin
      unique case (cmd_e)
        CMD_RD, CMD_RD_AP: start_rd = 1'b1;
        CMD_WR, CMD_WR_AP: start_wr = 1'b1;
        CMD_PRE:           stop     = (bank == burst_bank);
        CMD_PREALL:        stop     = 1'b1;
        default:           ;
      endcase
    end
  end

endmodule

// File: rtl/sdp_burst_tracker.sv
module sdp_burst_tracker #(
  parameter int CNT_W  = 3,
  parameter int BANK_W = 1,
  parameter int LAT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_rd,
  input  logic              start_wr,
  input  logic              stop,
  input  logic [CNT_W-1:0]  len_m1,
  input  logic [BANK_W-1:0] bank_in,
  input  logic [LAT_W-1:0]  lat_in,
  output logic              rd_issue,
  output logic              wr_beat,
  output logic [LAT_W-1:0]  issue_lat,
  output logic [BANK_W-1:0] burst_bank
);

  logic [CNT_W-1:0]  left_q, left_d;
  logic              is_rd_q, is_rd_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [LAT_W-1:0]  lat_q, lat_d;
  logic              busy, cut, go_on, upd_en;

  assign busy  = (left_q != '0);
  assign cut   = stop | start_rd | start_wr;
  assign go_on = busy & ~cut;

  assign rd_issue   = start_rd | (go_on & is_rd_q);
  assign wr_beat    = start_wr | (go_on & ~is_rd_q);
  assign issue_lat  = start_rd ? lat_in : lat_q;
  assign burst_bank = bank_q;
  assign upd_en     = start_rd | start_wr | stop | busy;

  always_comb begin
    left_d  = left_q;
    is_rd_d = is_rd_q;
    bank_d  = bank_q;
    lat_d   = lat_q;
    if (start_rd || start_wr) begin
      left_d  = len_m1;
      is_rd_d = start_rd;
      bank_d  = bank_in;
      lat_d   = lat_in;
    end else if (stop) begin
      left_d  = '0;
    end else if (busy) begin
      left_d  = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      is_rd_q <= 1'b0;
      bank_q  <= '0;
      lat_q   <= '0;
    end else if (upd_en) begin
      left_q  <= left_d;
      is_rd_q <= is_rd_d;
      bank_q  <= bank_d;
      lat_q   <= lat_d;
    end
  end

endmodule

// File: rtl/sdp_read_pipe.sv
module sdp_read_pipe #(
  parameter int MAX_CL = 3,
  parameter int LAT_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [LAT_W-1:0] issue_lat,
  output logic             data_valid,
  output logic             bus_drive
);

  logic [MAX_CL-1:0] vld_q;
  logic [LAT_W-1:0]  lat_q [MAX_CL];

  for (genvar g = 0; g < MAX_CL; g++) begin : g_age
    logic             vld_d;
    logic [LAT_W-1:0] lat_d;
    if (g == 0) begin : g_head
      assign vld_d = issue;
      assign lat_d = issue_lat;
    end else begin : g_body
      assign vld_d = vld_q[g-1];
      assign lat_d = lat_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
        lat_q[g] <= '0;
      end else begin
        vld_q[g] <= vld_d;
        lat_q[g] <= lat_d;
      end
    end
  end

  always_comb begin
    data_valid = 1'b0;
    bus_drive  = 1'b0;
    for (int k = 0; k < MAX_CL; k++) begin
      if (vld_q[k] && (int'(lat_q[k]) == k + 1)) begin
        data_valid = 1'b1;
        bus_drive  = 1'b1;
      end
      if (vld_q[k] && (int'(lat_q[k]) == k + 2)) begin
        bus_drive  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sdp_mask_delay.sv
module sdp_mask_delay #(
  parameter int NB    = 2,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] din,
  output logic [NB-1:0] dout
);

  logic [NB-1:0] stg_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic [NB-1:0] stg_d;
    if (g == 0) begin : g_head
      assign stg_d = din;
    end else begin : g_body
      assign stg_d = stg_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= '0;
      else        stg_q[g] <= stg_d;
    end
  end

  assign dout = stg_q[DEPTH-1];

endmodule

// File: rtl/sdram_dq_sequencer.sv
module sdram_dq_sequencer
  import sdp_pkg::*;
#(
  parameter int DQ_W        = 16,
  parameter int BYTE_W      = 8,
  parameter int BANK_W      = 1,
  parameter int MAX_CL      = 3,
  parameter int MAX_BL      = 8,
  parameter int RD_MASK_LAT = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_cl3,
  input  logic [1:0]               cfg_burst,
  input  logic                     cs_n,
  input  logic [2:0]               cmd,
  input  logic [BANK_W-1:0]        bank,
  input  logic [DQ_W/BYTE_W-1:0]   dqm,
  output logic                     dq_oe,
  output logic [DQ_W/BYTE_W-1:0]   dq_wr_be,
  output logic                     rd_capture,
  output logic [DQ_W/BYTE_W-1:0]   rd_be,
  output logic                     rd_bus_busy
);

  localparam int NB    = DQ_W / BYTE_W;
  localparam int LAT_W = $clog2(MAX_CL + 1);
  localparam int CNT_W = $clog2(MAX_BL);

  logic              start_rd, start_wr, stop;
  logic              rd_issue, wr_beat;
  logic [LAT_W-1:0]  lat_sel, issue_lat;
  logic [CNT_W-1:0]  len_m1;
  logic [BANK_W-1:0] burst_bank;
  logic              pipe_valid, pipe_drive;
  logic [NB-1:0]     dqm_late;

  assign lat_sel = cfg_cl3 ? LAT_W'(MAX_CL) : LAT_W'(MAX_CL - 1);

  always_comb begin
    unique case (cfg_burst)
      2'd0:    len_m1 = '0;
      2'd1:    len_m1 = CNT_W'(1);
      2'd2:    len_m1 = CNT_W'(3);
      default: len_m1 = CNT_W'(7);
    endcase
  end

  sdp_cmd_decode #(.BANK_W(BANK_W)) i_decode (
    .cmd        (cmd),
    .cs_n       (cs_n),
    .bank       (bank),
    .burst_bank (burst_bank),
    .start_rd   (start_rd),
    .start_wr   (start_wr),
    .stop       (stop)
  );

  sdp_burst_tracker #(.CNT_W(CNT_W), .BANK_W(BANK_W), .LAT_W(LAT_W)) i_tracker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_rd   (start_rd),
    .start_wr   (start_wr),
    .stop       (stop),
    .len_m1     (len_m1),
    .bank_in    (bank),
    .lat_in     (lat_sel),
    .rd_issue   (rd_issue),
    .wr_beat    (wr_beat),
    .issue_lat  (issue_lat),
    .burst_bank (burst_bank)
  );

  sdp_read_pipe #(.MAX_CL(MAX_CL), .LAT_W(LAT_W)) i_rd_pipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (rd_issue),
    .issue_lat  (issue_lat),
    .data_valid (pipe_valid),
    .bus_drive  (pipe_drive)
  );

  sdp_mask_delay #(.NB(NB), .DEPTH(RD_MASK_LAT)) i_rd_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (dqm),
    .dout  (dqm_late)
  );

  assign dq_oe       = wr_beat;
  assign dq_wr_be    = wr_beat ? ~dqm : '0;
  assign rd_capture  = pipe_valid & ~wr_beat;
  assign rd_bus_busy = pipe_drive & ~wr_beat;
  assign rd_be       = rd_capture ? ~dqm_late : '0;

endmodule

// File: rtl/sdp_checker.sv
module sdp_checker #(
  parameter int NB = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_cl3,
  input logic          cs_n,
  input logic [2:0]    cmd,
  input logic [NB-1:0] dqm,
  input logic          dq_oe,
  input logic [NB-1:0] dq_wr_be,
  input logic          rd_capture,
  input logic [NB-1:0] rd_be,
  input logic          rd_bus_busy
);

  logic wr_cmd, rd_cmd;

  assign wr_cmd = !cs_n && (cmd == 3'd3 || cmd == 3'd4);
  assign rd_cmd = !cs_n && (cmd == 3'd1 || cmd == 3'd2);

  AST_WR_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |-> dq_oe); // R2

  AST_WR_MASK_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (dq_wr_be == ~dqm)); // R5

  AST_WR_BE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_wr_be == '0)); // R5

  AST_RD_MASK_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |-> (rd_be == ~$past(dqm, 2))); // R6

  AST_RD_BE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_capture |-> (rd_be == '0)); // R6

  AST_CAPTURE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |-> rd_bus_busy); // R4

  AST_BUS_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!rd_capture && !rd_bus_busy)); // R11

  AST_CL2_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(rd_cmd, 2) && !$past(cfg_cl3, 2) && !dq_oe) |-> rd_capture); // R3

  AST_CL3_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 3) && $past(rd_cmd, 3) && $past(cfg_cl3, 3) && !dq_oe) |-> rd_capture); // R3

endmodule

bind sdram_dq_sequencer sdp_checker #(.NB(NB)) i_sdp_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_cl3     (cfg_cl3),
  .cs_n        (cs_n),
  .cmd         (cmd),
  .dqm         (dqm),
  .dq_oe       (dq_oe),
  .dq_wr_be    (dq_wr_be),
  .rd_capture  (rd_capture),
  .rd_be       (rd_be),
  .rd_bus_busy (rd_bus_busy)
);

// File: tb/test_sdram_dq_sequencer.sv
module test_sdram_dq_sequencer;

  localparam int NCYC = 24;
  localparam logic [2:0] C_NOP = 3'd0, C_RD = 3'd1, C_RDA = 3'd2, C_WR = 3'd3,
                         C_WRA = 3'd4, C_PRE = 3'd5, C_PALL = 3'd6;

  logic       clk, rst_n, cfg_cl3, cs_n, bank;
  logic [1:0] cfg_burst, dqm, dq_wr_be, rd_be;
  logic [2:0] cmd;
  logic       dq_oe, rd_capture, rd_bus_busy;

  int n_chk = 0;
  int n_fail = 0;

  logic [2:0] s_cmd  [NCYC];
  logic       s_bank [NCYC];
  logic       s_csn  [NCYC];
  logic [1:0] s_dqm  [NCYC];
  logic       s_cl3  [NCYC];
  logic [NCYC-1:0] o_oe, o_rv, o_drv;
  logic [1:0] o_wbe [NCYC];
  logic [1:0] o_rbe [NCYC];

  sdram_dq_sequencer i_sdram_dq_sequencer (
    .clk(clk), .rst_n(rst_n), .cfg_cl3(cfg_cl3), .cfg_burst(cfg_burst),
    .cs_n(cs_n), .cmd(cmd), .bank(bank), .dqm(dqm),
    .dq_oe(dq_oe), .dq_wr_be(dq_wr_be), .rd_capture(rd_capture),
    .rd_be(rd_be), .rd_bus_busy(rd_bus_busy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clear_seq(input logic cl3, input logic [1:0] bl);
    cfg_burst = bl;
    for (int i = 0; i < NCYC; i++) begin
      s_cmd[i] = C_NOP; s_bank[i] = 1'b0; s_csn[i] = 1'b0;
      s_dqm[i] = 2'b00; s_cl3[i] = cl3;
    end
  endtask

  task automatic run_seq();
    for (int i = 0; i < NCYC; i++) begin
      @(negedge clk);
      cmd = s_cmd[i]; bank = s_bank[i]; cs_n = s_csn[i];
      dqm = s_dqm[i]; cfg_cl3 = s_cl3[i];
      #1;
      o_oe[i] = dq_oe; o_rv[i] = rd_capture; o_drv[i] = rd_bus_busy;
      o_wbe[i] = dq_wr_be; o_rbe[i] = rd_be;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cmd = C_NOP; cs_n = 1'b1; bank = 1'b0; dqm = 2'b00;
    cfg_cl3 = 1'b0; cfg_burst = 2'd0;
    repeat (3) @(negedge clk);
    chk("R1 during reset", {27'd0, dq_oe, dq_wr_be, rd_capture, rd_be == 2'b00 ? 1'b0 : 1'b1}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R1 idle after reset", {25'd0, dq_oe, dq_wr_be, rd_capture, rd_be, rd_bus_busy}, 32'd0);
  endtask

  task automatic t_read_basic();
    clear_seq(1'b0, 2'd2); s_cmd[0] = C_RD; run_seq();
    chk("R3 cl2 bl4 capture", 32'(o_rv), 32'h3C);
    chk("R4 cl2 bl4 bus busy", 32'(o_drv), 32'h3E);
    clear_seq(1'b1, 2'd1); s_cmd[0] = C_RD; run_seq();
    chk("R3 cl3 bl2 capture", 32'(o_rv), 32'h18);
    chk("R4 cl3 bl2 bus busy", 32'(o_drv), 32'h1C);
  endtask

  task automatic t_write_basic();
    clear_seq(1'b0, 2'd3); s_cmd[0] = C_WR; run_seq();
    chk("R2 write bl8", 32'(o_oe), 32'hFF);
    clear_seq(1'b0, 2'd0); s_cmd[0] = C_WR; run_seq();
    chk("R2 write bl1", 32'(o_oe), 32'h1);
  endtask

  task automatic t_auto_pre();
    clear_seq(1'b0, 2'd1); s_cmd[0] = C_RDA; run_seq();
    chk("R10 read+AP capture", 32'(o_rv), 32'hC);
    chk("R10 read+AP bus busy", 32'(o_drv), 32'hE);
    clear_seq(1'b0, 2'd1); s_cmd[0] = C_WRA; run_seq();
    chk("R10 write+AP beats", 32'(o_oe), 32'h3);
  endtask

  task automatic t_precharge();
    clear_seq(1'b1, 2'd3); s_cmd[0] = C_RD; s_cmd[2] = C_PALL; run_seq();
    chk("R7 cl3 precharge-all capture", 32'(o_rv), 32'h18);
    chk("R7 cl3 precharge-all release", 32'(o_drv), 32'h1C);
    clear_seq(1'b0, 2'd3); s_cmd[0] = C_RD; s_cmd[3] = C_PRE; run_seq();
    chk("R7 cl2 same-bank capture", 32'(o_rv), 32'h1C);
    chk("R7 cl2 same-bank release", 32'(o_drv), 32'h1E);
    clear_seq(1'b0, 2'd2); s_cmd[0] = C_RD; s_cmd[1] = C_PRE; s_bank[1] = 1'b1; run_seq();
    chk("R7 other-bank no effect", 32'(o_rv), 32'h3C);
    clear_seq(1'b0, 2'd3); s_cmd[0] = C_WR; s_bank[0] = 1'b1;
    s_cmd[4] = C_PRE; s_bank[4] = 1'b1; run_seq();
    chk("R7 write cut", 32'(o_oe), 32'hF);
  endtask

  task automatic t_interrupt();
    clear_seq(1'b0, 2'd3); s_cmd[0] = C_RD; s_cmd[3] = C_WR; run_seq();
    chk("R8 write after read beats", 32'(o_oe), 32'h7F8);
    chk("R11 capture suppressed", 32'(o_rv), 32'h4);
    chk("R11 bus busy suppressed", 32'(o_drv), 32'h6);
    clear_seq(1'b0, 2'd2); s_cmd[0] = C_WR; s_cmd[2] = C_RD; run_seq();
    chk("R8 write cut by read", 32'(o_oe), 32'h3);
    chk("R8 read after write capture", 32'(o_rv), 32'hF0);
    chk("R8 read after write busy", 32'(o_drv), 32'hF8);
  endtask

  task automatic t_chip_select();
    clear_seq(1'b0, 2'd2);
    s_cmd[0] = C_RD; s_csn[0] = 1'b1; s_cmd[3] = C_WR; s_csn[3] = 1'b1; run_seq();
    chk("R9 deselected read", 32'(o_rv | o_drv), 32'h0);
    chk("R9 deselected write", 32'(o_oe), 32'h0);
  endtask

  task automatic t_latency_latch();
    clear_seq(1'b1, 2'd2); s_cl3[0] = 1'b0; s_cmd[0] = C_RD; run_seq();
    chk("R12 cl2 kept after switch", 32'(o_rv), 32'h3C);
    clear_seq(1'b0, 2'd2); s_cl3[0] = 1'b1; s_cmd[0] = C_RD; run_seq();
    chk("R12 cl3 kept after switch", 32'(o_rv), 32'h78);
  endtask

  task automatic t_masks();
    clear_seq(1'b0, 2'd2); s_cmd[0] = C_WR;
    s_dqm[0] = 2'b01; s_dqm[1] = 2'b10; s_dqm[2] = 2'b00; s_dqm[3] = 2'b11; s_dqm[4] = 2'b01;
    run_seq();
    chk("R5 write mask beats", {24'd0, o_wbe[0], o_wbe[1], o_wbe[2], o_wbe[3]}, {24'd0, 8'b10_01_11_00});
    chk("R5 write mask idle", 32'(o_wbe[4]), 32'h0);
    clear_seq(1'b0, 2'd1); s_cmd[0] = C_RD;
    s_dqm[0] = 2'b10; s_dqm[1] = 2'b01;
    for (int i = 2; i < NCYC; i++) s_dqm[i] = 2'b11;
    run_seq();
    chk("R6 read mask lag", {28'd0, o_rbe[2], o_rbe[3]}, {28'd0, 4'b01_10});
    chk("R6 read mask idle", {28'd0, o_rbe[1], o_rbe[4]}, 32'h0);
  endtask

  initial begin
    t_reset();
    t_read_basic();
    t_write_basic();
    t_auto_pre();
    t_precharge();
    t_interrupt();
    t_chip_select();
    t_latency_latch();
    t_masks();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule